// File: doc/BRIEF.md
# Page Translation Cache with Table Walker

This block turns 32-bit virtual addresses into physical addresses for a system with 4 KB pages. Each request carries a virtual address and an access kind (read, write or instruction fetch). The upper 20 bits of the address are the page number and the low 12 bits are the in-page offset. A small fully associative cache of recent translations answers most requests in one cycle. A request that misses is resolved by a walker, which reads the page table entry from a single-level table in memory, updates the entry's bookkeeping bits in memory when needed, and installs the translation in the cache.

Requests enter on a valid/ready handshake. The block holds `req_ready_o` low for the whole of a table walk, so the requester sees back-pressure exactly while the memory port is busy. Responses leave as single-cycle pulses on `rsp_valid_o` and have no back-pressure: the consumer must take each pulse. The table base, the table length (in pages) and the cache flush are plain control inputs. Faults are reported on the response and never stall the block.

The memory port is a simple request/acknowledge port. The block holds `mem_req_o` with stable address, direction and write data until `mem_ack_i` is seen high at a clock edge. Read data is taken in the cycle of that acknowledge.

Top module: `vaddr_xlate`

## Requirements
- R1: When a request hits a cached translation that permits the access and needs no modified-bit update, the physical address `{frame, offset}` is presented with `rsp_valid_o` one cycle after acceptance. There is no memory access, and `req_ready_o` stays high, so hits can be accepted on consecutive cycles.
- R2: A request that misses reads one 32-bit word at `pt_base_i + 4*page_number`. `req_ready_o` is low from the cycle after acceptance until the cycle after the walk completes. `mem_req_o` holds its address, direction and data stable until acknowledged.
- R3: An entry has frame number in bits 19:0, protection in bits 21:20, modified in bit 22, referenced in bit 23 and valid in bit 24. A walked entry with bit 24 clear gives fault code 2. It causes no memory write and no install, so a later access to that page walks again. On any fault `rsp_paddr_o` is zero.
- R4: After a walk that permits the access, the entry is written back to the same address before the response, with bit 23 set and, for a write access, bit 22 set. The write-back happens only if that changes the word. No other memory write ever occurs.
- R5: A permitted write that hits a cached entry whose modified bit is clear is handled as a walk (read, then write-back). The refreshed translation overwrites that same cache slot and does not advance the replacement pointer. A following write to the page hits.
- R6: A page number at or above `pt_len_i` gives fault code 1 one cycle after acceptance, with no memory access. This check comes before the cache lookup.
- R7: Protection codes are 0 none, 1 read only, 2 read and write, 3 read and execute. Access kinds are 0 read, 1 write, 2 execute, and 3 reserved, which is never permitted. A forbidden access gives fault code 3. On a hit this involves no memory access; after a walk the entry is neither written back nor installed.
- R8: New translations fill the 8 cache slots in round-robin order, starting at slot 0 after reset and after a flush. The ninth distinct page installed evicts the first.
- R9: `flush_i` high at a clock edge invalidates every cached translation at that edge, so the next access to any page walks.
- R10: A request is taken only when `req_valid_i` and `req_ready_o` are both high at a clock edge, and each accepted request yields exactly one single-cycle response. Fault code 0 means success.
- R11: After reset, `req_ready_o` is high, `rsp_valid_o` and `mem_req_o` are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cached translations |
| pt_base_i | input | 32 | Physical byte address of page table |
| pt_len_i | input | 21 | Number of pages the table covers |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_op_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 2 | 0 ok, 1 beyond table, 2 not valid, 3 protection |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access completes this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |

## Verification
The assertions check, on every cycle, that the memory request stays stable until acknowledged and never overlaps an open request slot. They also check that every response follows an acceptance or a memory completion, that out-of-range pages fault on the next cycle, that faulted responses carry a zero address, and that every write-back carries the referenced bit. The outcome of each request depends on the history of installs, flushes and table contents: which requests hit, the round-robin eviction order, the reuse of a slot after a modified-bit upgrade, and the final memory image. Only the bench's scenarios, checked against a reference model of the cache, can show these.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int PG_OFF_W    = 12;
  localparam int FRM_W       = 20;
  localparam int PTE_W       = 32;
  localparam int PTE_PROT_LO = 20;
  localparam int PTE_MOD     = 22;
  localparam int PTE_REF     = 23;
  localparam int PTE_VLD     = 24;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE    = 2'd0;
  localparam logic [1:0] FLT_BOUND   = 2'd1;
  localparam logic [1:0] FLT_INVALID = 2'd2;
  localparam logic [1:0] FLT_PROT    = 2'd3;

  localparam logic [1:0] PR_RO = 2'd1;
  localparam logic [1:0] PR_RW = 2'd2;
  localparam logic [1:0] PR_RX = 2'd3;

  typedef enum logic [1:0] {WK_IDLE, WK_READ, WK_WRITE} walk_st_e;

  function automatic logic op_allowed(input logic [1:0] op, input logic [1:0] prot);
    logic ok;
    case (op)
      OP_READ:  ok = (prot != 2'd0);
      OP_WRITE: ok = (prot == PR_RW);
      OP_EXEC:  ok = (prot == PR_RX);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/xl_tlb_cam.sv
module xl_tlb_cam
  import xl_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [FRM_W-1:0] lk_frame_o,
  output logic [1:0]       lk_prot_o,
  output logic             lk_dirty_o,
  input  logic             ins_en_i,
  input  logic             ins_reuse_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic [VPN_W-1:0] ins_vpn_i,
  input  logic [FRM_W-1:0] ins_frame_i,
  input  logic [1:0]       ins_prot_i,
  input  logic             ins_dirty_i
);
  logic [ENTRIES-1:0] match;
  logic [FRM_W-1:0]   frm_w  [ENTRIES];
  logic [1:0]         prot_w [ENTRIES];
  logic [ENTRIES-1:0] dirty_w;
  logic [IDX_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   tgt;

  assign tgt = ins_reuse_i ? ins_idx_i : ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_r;
    logic [VPN_W-1:0] vpn_r;
    logic [FRM_W-1:0] frm_r;
    logic [1:0]       prot_r;
    logic             dirty_r;
    logic             wr_sel;

    assign wr_sel     = ins_en_i && (tgt == IDX_W'(g));
    assign match[g]   = vld_r && (vpn_r == lk_vpn_i);
    assign frm_w[g]   = frm_r;
    assign prot_w[g]  = prot_r;
    assign dirty_w[g] = dirty_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r   <= 1'b0;
        vpn_r   <= '0;
        frm_r   <= '0;
        prot_r  <= '0;
        dirty_r <= 1'b0;
      end else if (flush_i) begin
        vld_r <= 1'b0;
      end else if (wr_sel) begin
        vld_r   <= 1'b1;
        vpn_r   <= ins_vpn_i;
        frm_r   <= ins_frame_i;
        prot_r  <= ins_prot_i;
        dirty_r <= ins_dirty_i;
      end
    end
  end

  always_comb begin
    lk_hit_o   = |match;
    lk_idx_o   = '0;
    lk_frame_o = '0;
    lk_prot_o  = '0;
    lk_dirty_o = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx_o   = IDX_W'(i);
        lk_frame_o = frm_w[i];
        lk_prot_o  = prot_w[i];
        lk_dirty_o = dirty_w[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
    end else if (ins_en_i && !ins_reuse_i) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xl_walker.sv
module xl_walker
  import xl_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [1:0]       op_i,
  input  logic [PA_W-1:0]  base_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [1:0]       fin_fault_o,
  output logic [PTE_W-1:0] fin_pte_o
);
  walk_st_e         st_q;
  logic [1:0]       op_q;
  logic [PA_W-1:0]  addr_q;
  logic [PTE_W-1:0] wdata_q;
  logic [PTE_W-1:0] pte_upd;
  logic             go_write;

  assign pte_upd = mem_rdata_i
                 | (PTE_W'(1) << PTE_REF)
                 | ((op_q == OP_WRITE) ? (PTE_W'(1) << PTE_MOD) : '0);

  always_comb begin
    fin_o       = 1'b0;
    fin_fault_o = FLT_NONE;
    fin_pte_o   = mem_rdata_i;
    go_write    = 1'b0;
    case (st_q)
      WK_READ: begin
        if (mem_ack_i) begin
          if (!mem_rdata_i[PTE_VLD]) begin
            fin_o       = 1'b1;
            fin_fault_o = FLT_INVALID;
          end else if (!op_allowed(op_q, mem_rdata_i[PTE_PROT_LO +: 2])) begin
            fin_o       = 1'b1;
            fin_fault_o = FLT_PROT;
          end else if (pte_upd != mem_rdata_i) begin
            go_write = 1'b1;
          end else begin
            fin_o = 1'b1;
          end
        end
      end
      WK_WRITE: begin
        if (mem_ack_i) begin
          fin_o     = 1'b1;
          fin_pte_o = wdata_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (start_i) begin
            st_q   <= WK_READ;
            op_q   <= op_i;
            addr_q <= base_i + PA_W'({vpn_i, 2'b00});
          end
        end
        WK_READ: begin
          if (mem_ack_i) begin
            if (go_write) begin
              st_q    <= WK_WRITE;
              wdata_q <= pte_upd;
            end else begin
              st_q <= WK_IDLE;
            end
          end
        end
        WK_WRITE: begin
          if (mem_ack_i) st_q <= WK_IDLE;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != WK_IDLE);
  assign mem_req_o   = (st_q != WK_IDLE);
  assign mem_we_o    = (st_q == WK_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xl_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int TLB_ENTRIES = 8,
  localparam int VPN_W      = VA_W - PG_OFF_W,
  localparam int PA_W       = FRM_W + PG_OFF_W,
  localparam int IDX_W      = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [PA_W-1:0]  pt_base_i,
  input  logic [VPN_W:0]   pt_len_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_op_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [VPN_W-1:0]    req_vpn;
  logic [PG_OFF_W-1:0] req_off;
  logic                acc, out_of_range, perm_ok, need_mod;
  logic                lk_hit, lk_dirty;
  logic [IDX_W-1:0]    lk_idx;
  logic [FRM_W-1:0]    lk_frame;
  logic [1:0]          lk_prot;
  logic                imm_rsp, start_walk;
  logic [1:0]          imm_fault;
  logic [PA_W-1:0]     imm_paddr;
  logic                wk_busy, wk_fin;
  logic [1:0]          wk_fault;
  logic [PTE_W-1:0]    wk_pte;
  logic [VPN_W-1:0]    vpn_q;
  logic [PG_OFF_W-1:0] off_q;
  logic                reuse_q;
  logic [IDX_W-1:0]    idx_q;
  logic                ins_en;
  logic                rsp_valid_q;
  logic [PA_W-1:0]     rsp_paddr_q;
  logic [1:0]          rsp_fault_q;

  assign req_vpn      = req_vaddr_i[VA_W-1:PG_OFF_W];
  assign req_off      = req_vaddr_i[PG_OFF_W-1:0];
  assign req_ready_o  = !wk_busy;
  assign acc          = req_valid_i && req_ready_o;
  assign out_of_range = ({1'b0, req_vpn} >= pt_len_i);
  assign perm_ok      = op_allowed(req_op_i, lk_prot);
  assign need_mod     = (req_op_i == OP_WRITE) && !lk_dirty;

  xl_tlb_cam #(.VPN_W(VPN_W), .ENTRIES(TLB_ENTRIES)) cam_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .lk_vpn_i    (req_vpn),
    .lk_hit_o    (lk_hit),
    .lk_idx_o    (lk_idx),
    .lk_frame_o  (lk_frame),
    .lk_prot_o   (lk_prot),
    .lk_dirty_o  (lk_dirty),
    .ins_en_i    (ins_en),
    .ins_reuse_i (reuse_q),
    .ins_idx_i   (idx_q),
    .ins_vpn_i   (vpn_q),
    .ins_frame_i (wk_pte[FRM_W-1:0]),
    .ins_prot_i  (wk_pte[PTE_PROT_LO +: 2]),
    .ins_dirty_i (wk_pte[PTE_MOD])
  );

  xl_walker #(.VPN_W(VPN_W), .PA_W(PA_W)) walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_walk),
    .vpn_i       (req_vpn),
    .op_i        (req_op_i),
    .base_i      (pt_base_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (wk_busy),
    .fin_o       (wk_fin),
    .fin_fault_o (wk_fault),
    .fin_pte_o   (wk_pte)
  );

  // Decide at acceptance: range first, then cached permission, then hit/walk.
  always_comb begin
    imm_rsp    = 1'b0;
    imm_fault  = FLT_NONE;
    imm_paddr  = '0;
    start_walk = 1'b0;
    if (acc) begin
      if (out_of_range) begin
        imm_rsp   = 1'b1;
        imm_fault = FLT_BOUND;
      end else if (lk_hit && !perm_ok) begin
        imm_rsp   = 1'b1;
        imm_fault = FLT_PROT;
      end else if (lk_hit && !need_mod) begin
        imm_rsp   = 1'b1;
        imm_paddr = {lk_frame, req_off};
      end else begin
        start_walk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      off_q   <= '0;
      reuse_q <= 1'b0;
      idx_q   <= '0;
    end else if (start_walk) begin
      vpn_q   <= req_vpn;
      off_q   <= req_off;
      reuse_q <= lk_hit;
      idx_q   <= lk_idx;
    end
  end

  assign ins_en = wk_fin && (wk_fault == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= FLT_NONE;
    end else begin
      rsp_valid_q <= imm_rsp || wk_fin;
      if (wk_fin) begin
        rsp_fault_q <= wk_fault;
        rsp_paddr_q <= (wk_fault == FLT_NONE) ? {wk_pte[FRM_W-1:0], off_q} : '0;
      end else if (imm_rsp) begin
        rsp_fault_q <= imm_fault;
        rsp_paddr_q <= imm_paddr;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_paddr_o = rsp_paddr_q;
  assign rsp_fault_o = rsp_fault_q;
endmodule

// File: rtl/xl_chk.sv
module xl_chk
  import xl_pkg::*;
#(
  parameter int VA_W = 32,
  localparam int VPN_W = VA_W - PG_OFF_W,
  localparam int PA_W  = FRM_W + PG_OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VPN_W:0]   pt_len_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic [1:0]       rsp_fault_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic [PTE_W-1:0] mem_wdata_o,
  input logic             mem_ack_i
);
  // R2
  walk_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !req_ready_o);

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R10
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($past(req_valid_i && req_ready_o) || $past(mem_req_o && mem_ack_i)));

  // R6
  bound_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && ({1'b0, req_vaddr_i[VA_W-1:PG_OFF_W]} >= pt_len_i))
    |=> (rsp_valid_o && rsp_fault_o == FLT_BOUND));

  // R3
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_paddr_o == '0));

  // R4
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[PTE_REF]);
endmodule

bind vaddr_xlate xl_chk #(.VA_W(VA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pt_len_i    (pt_len_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/vaddr_xlate_tb_top.sv
module vaddr_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPG = 64;
  localparam int PTLEN = 48;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] pt_base_i = BASE;
  logic [20:0] pt_len_i = 21'(PTLEN);
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_op_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  vaddr_xlate dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, mlat = 0, exp_vpn = 0;
  logic [31:0] pt_mem [NPG];
  logic [31:0] pt_exp [NPG];
  bit          sl_v [8];
  int          sl_vpn [8];
  logic [19:0] sl_frm [8];
  logic [1:0]  sl_prot [8];
  bit          sl_d [8];
  int          sl_ptr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit allowed(input logic [1:0] op, input logic [1:0] prot);
    if (op == 2'd0) return prot != 2'd0;
    if (op == 2'd1) return prot == 2'd2;
    if (op == 2'd2) return prot == 2'd3;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mk_pte(input bit v, input bit r, input bit m,
                                         input logic [1:0] p, input logic [19:0] f);
    return {7'd0, v, r, m, p, f};
  endfunction

  task automatic set_pte(input int vpn, input logic [31:0] val);
    pt_mem[vpn] = val;
    pt_exp[vpn] = val;
  endtask

  task automatic model_flush();
    for (int i = 0; i < 8; i++) sl_v[i] = 1'b0;
    sl_ptr = 0;
  endtask

  // memory responder: random latency, acknowledges on negedge
  initial begin
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (rst_n && mem_req_o) begin
        if (mlat == 0) begin
          int idx;
          idx = int'((mem_addr_o - BASE) >> 2);
          chk(idx == exp_vpn, mem_we_o ? "R4" : "R2", "table address",
              64'(mem_addr_o), 64'(BASE + 32'(exp_vpn) * 4));
          mem_ack_i = 1'b1;
          if (idx >= 0 && idx < NPG) begin
            if (mem_we_o) begin
              pt_mem[idx] = mem_wdata_o;
              wr_cnt++;
            end else begin
              mem_rdata_i = pt_mem[idx];
              rd_cnt++;
            end
          end
          mlat = int'($urandom_range(0, 2));
        end else begin
          mlat--;
        end
      end
    end
  end

  task automatic do_access(input int vpn, input logic [11:0] off, input logic [1:0] op);
    int hit_i, exp_reads, exp_writes, lat, rd0, wr0, slot;
    bit walk;
    logic [1:0] ef;
    logic [31:0] ep, pte, upd;
    string tag;
    hit_i = -1; exp_reads = 0; exp_writes = 0; walk = 0; ef = 2'd0; ep = '0;
    tag = "R1";
    if (vpn >= PTLEN) begin
      ef = 2'd1; tag = "R6";
    end else begin
      for (int i = 0; i < 8; i++) if (sl_v[i] && sl_vpn[i] == vpn) hit_i = i;
      if (hit_i >= 0 && !allowed(op, sl_prot[hit_i])) begin
        ef = 2'd3; tag = "R7";
      end else if (hit_i >= 0 && !(op == 2'd1 && !sl_d[hit_i])) begin
        ep = {sl_frm[hit_i], off};
      end else begin
        walk = 1; exp_reads = 1;
        tag = (hit_i >= 0) ? "R5" : "R2";
        pte = pt_exp[vpn];
        if (!pte[24]) begin
          ef = 2'd2; tag = "R3";
        end else if (!allowed(op, pte[21:20])) begin
          ef = 2'd3; tag = "R7";
        end else begin
          upd = pte | (32'd1 << 23) | ((op == 2'd1) ? (32'd1 << 22) : 32'd0);
          if (upd != pte) begin
            exp_writes = 1;
            pt_exp[vpn] = upd;
          end
          slot = (hit_i >= 0) ? hit_i : sl_ptr;
          if (hit_i < 0) sl_ptr = (sl_ptr + 1) % 8;
          sl_v[slot] = 1'b1; sl_vpn[slot] = vpn; sl_frm[slot] = upd[19:0];
          sl_prot[slot] = upd[21:20]; sl_d[slot] = upd[22];
          ep = {upd[19:0], off};
        end
      end
    end
    exp_vpn = vpn;
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid_i = 1'b1;
    req_vaddr_i = {20'(vpn), off};
    req_op_i = op;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 1;
    if (walk) chk(!req_ready_o, "R2", "ready during walk", 64'(req_ready_o), 64'd0);
    while (!rsp_valid_o) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_fault_o == ef, tag, "fault code", 64'(rsp_fault_o), 64'(ef));
    chk(rsp_paddr_o == ep, tag, "physical address", 64'(rsp_paddr_o), 64'(ep));
    chk(rd_cnt - rd0 == exp_reads, tag, "table reads", 64'(rd_cnt - rd0), 64'(exp_reads));
    chk(wr_cnt - wr0 == exp_writes, "R4", "table writes", 64'(wr_cnt - wr0), 64'(exp_writes));
    if (!walk) chk(lat == 1, tag, "response latency", 64'(lat), 64'd1);
    @(negedge clk);
    chk(!rsp_valid_o, "R10", "single response pulse", 64'(rsp_valid_o), 64'd0);
  endtask

  task automatic do_flush();
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    model_flush();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int rd0;
    void'($urandom(32'h5EED_0001));
    model_flush();
    for (int i = 0; i < NPG; i++)
      set_pte(i, mk_pte(($urandom % 5) != 0, 1'($urandom), 1'($urandom),
                        2'($urandom), 20'($urandom)));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready_o, "R11", "ready after reset", 64'(req_ready_o), 64'd1);
    chk(!rsp_valid_o, "R11", "no response in reset", 64'(rsp_valid_o), 64'd0);
    chk(!mem_req_o, "R11", "no memory request in reset", 64'(mem_req_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 back-to-back hits
    set_pte(1, mk_pte(1, 1, 0, 2'd1, 20'hAAAA1));
    set_pte(2, mk_pte(1, 1, 0, 2'd3, 20'hBBBB2));
    do_access(1, 12'h010, 2'd0);
    do_access(2, 12'h020, 2'd2);
    rd0 = rd_cnt;
    req_valid_i = 1'b1; req_vaddr_i = {20'd1, 12'h123}; req_op_i = 2'd0;
    @(negedge clk);
    chk(rsp_valid_o && rsp_paddr_o == {20'hAAAA1, 12'h123}, "R1", "first of back-to-back",
        64'(rsp_paddr_o), 64'({20'hAAAA1, 12'h123}));
    chk(req_ready_o, "R1", "ready held on hits", 64'(req_ready_o), 64'd1);
    req_vaddr_i = {20'd2, 12'h456}; req_op_i = 2'd2;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(rsp_valid_o && rsp_paddr_o == {20'hBBBB2, 12'h456}, "R1", "second of back-to-back",
        64'(rsp_paddr_o), 64'({20'hBBBB2, 12'h456}));
    chk(rd_cnt == rd0, "R1", "no reads on hits", 64'(rd_cnt - rd0), 64'd0);
    @(negedge clk);

    // R9 flush forces a walk
    do_flush();
    rd0 = rd_cnt;
    do_access(1, 12'h0, 2'd0);
    chk(rd_cnt - rd0 == 1, "R9", "walk after flush", 64'(rd_cnt - rd0), 64'd1);

    // R8 round-robin eviction
    do_flush();
    for (int v = 20; v <= 28; v++) set_pte(v, mk_pte(1, 1, 0, 2'd1, 20'(v * 3)));
    for (int v = 20; v <= 28; v++) do_access(v, 12'h004, 2'd0);
    rd0 = rd_cnt;
    do_access(21, 12'h008, 2'd0);
    chk(rd_cnt == rd0, "R8", "second page still cached", 64'(rd_cnt - rd0), 64'd0);
    do_access(20, 12'h008, 2'd0);
    chk(rd_cnt - rd0 == 1, "R8", "first page evicted", 64'(rd_cnt - rd0), 64'd1);

    // R3 invalid entry is not cached
    set_pte(30, mk_pte(0, 0, 0, 2'd2, 20'h12345));
    do_access(30, 12'h0, 2'd0);
    rd0 = rd_cnt;
    do_access(30, 12'h0, 2'd0);
    chk(rd_cnt - rd0 == 1, "R3", "invalid walks again", 64'(rd_cnt - rd0), 64'd1);

    // R5 write to clean cached page, then hit
    set_pte(31, mk_pte(1, 1, 0, 2'd2, 20'h31313));
    do_access(31, 12'hFFF, 2'd0);
    do_access(31, 12'h001, 2'd1);
    rd0 = rd_cnt;
    do_access(31, 12'h002, 2'd1);
    chk(rd_cnt == rd0, "R5", "dirty entry now hits", 64'(rd_cnt - rd0), 64'd0);

    // R7 protection
    set_pte(32, mk_pte(1, 0, 0, 2'd1, 20'h32323));
    do_access(32, 12'h0, 2'd1);
    do_access(32, 12'h0, 2'd0);
    do_access(32, 12'h0, 2'd3);
    do_access(32, 12'h0, 2'd2);

    // R6 table bound
    do_access(PTLEN - 1, 12'h0, 2'd0);
    do_access(PTLEN, 12'h0, 2'd0);
    do_access(63, 12'h7, 2'd1);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int v, r;
      logic [1:0] op;
      r = int'($urandom % 100);
      v = (r < 8) ? int'($urandom_range(40, 63)) : int'($urandom_range(0, 15));
      r = int'($urandom % 100);
      op = (r < 45) ? 2'd0 : (r < 80) ? 2'd1 : (r < 95) ? 2'd2 : 2'd3;
      if (($urandom % 40) == 0) do_flush();
      if (($urandom % 25) == 0) begin
        int mv;
        mv = int'($urandom_range(0, 15));
        set_pte(mv, mk_pte(($urandom % 4) != 0, 1'($urandom), 1'($urandom),
                           2'($urandom), 20'($urandom)));
      end
      do_access(v, 12'($urandom), op);
    end

    // R4 final table image
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < NPG; i++) if (pt_mem[i] !== pt_exp[i]) bad++;
      chk(bad == 0, "R4", "table image mismatches", 64'(bad), 64'd0);
    end
    finish_run();
  end
endmodule